// File: doc/BRIEF.md
# Sync Word Detector with Output Modes

This block watches a recovered serial receive stream, one bit per strobe of a bit-clock enable, and looks for a programmed sync word. Such a word normally follows an alternating 1/0 preamble and comes before the ID and payload fields. Each received bit enters a shift register. The newest bits are compared against the programmed word, and a match is declared when the number of differing bits is no greater than a programmed tolerance.

What a match does depends on a 2-bit mode:
- the outputs stay quiet;
- a detect level latches until it is cleared;
- detect stays high for a programmed number of payload bytes, after which searching resumes;
- a sticky interrupt is raised instead of detect.

A match also realigns a symbol-phase strobe. A receiver that carries two bits per symbol can then tell the first bit of each symbol from the second.

Top module: `sync_detect`

## Requirements
- R1: After reset, detect and irq are low and sym_first is high.
- R2: On each bit_en strobe the comparison window is the incoming bit (as bit 0) plus the previous cfg_len-1 bits (earliest received in bit cfg_len-1), compared with cfg_word[cfg_len-1:0] for cfg_len in 1..24. A match is declared when the mismatching bit count is at most cfg_tol (0..3).
- R3: With cfg_mode = 2'b00, detect and irq stay low whatever the stream carries.
- R4: With cfg_mode = 2'b01, detect rises one clock after the strobe that completes a match and stays high until sync_clr. No new search runs while it is high.
- R5: With cfg_mode = 2'b10 and cfg_pkt_bytes = N, detect rises one clock after the matching strobe and falls one clock after the 8N-th strobe that follows it. Search resumes after that. With N = 0, detect never rises.
- R6: With cfg_mode = 2'b11, a match raises irq one clock later and irq stays high until sync_clr. detect stays low.
- R7: A one-clock sync_clr pulse drives detect and irq low on the next clock and re-arms the search.
- R8: With four_level = 1, sym_first is high one clock after a matching strobe and toggles on every later non-matching strobe. With four_level = 0, sym_first is held high.
- R9: A window with cfg_tol+1 mismatching bits is not declared a match.
- R10: Without a bit_en strobe or a sync_clr pulse, and with the mode held, detect and irq keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-clock strobe marking a valid received bit |
| bit_in | input | 1 | Received bit, sampled when bit_en is high |
| cfg_mode | input | 2 | Output mode: 00 off, 01 latch, 10 packet, 11 interrupt |
| cfg_word | input | MAX_LEN | Sync word, last-sent bit in bit 0 |
| cfg_len | input | LEN_W | Sync word length in bits (1..MAX_LEN) |
| cfg_tol | input | 2 | Allowed mismatching bits |
| cfg_pkt_bytes | input | PKT_W | Payload length in bytes for packet mode |
| four_level | input | 1 | Symbols carry two bits each |
| sync_clr | input | 1 | Clears detect/irq and re-arms the search |
| detect | output | 1 | Sync detect level (modes 01 and 10) |
| irq | output | 1 | Sticky sync interrupt (mode 11) |
| sym_first | output | 1 | Next received bit is the first bit of a symbol |

## Verification
The assertions assume that cfg_mode, cfg_word, cfg_len, cfg_tol, cfg_pkt_bytes and four_level stay steady while a detect or irq is pending. They also assume that bit_en is a one-clock strobe and that sync_clr is never given in the same clock as a strobe. The stimulus sets all configuration during a sync_clr pulse with no strobe present. Each bit is sent as a single-clock strobe followed by an idle clock. Sync words are chosen so that no preamble or trailing-zero window falls within tolerance, which means the only matches are the intended ones.

// File: rtl/sync_detect.sv
module sync_detect #(
  parameter int MAX_LEN = 24,
  parameter int PKT_W   = 8,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bit_in,
  input  logic [1:0]         cfg_mode,
  input  logic [MAX_LEN-1:0] cfg_word,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [1:0]         cfg_tol,
  input  logic [PKT_W-1:0]   cfg_pkt_bytes,
  input  logic               four_level,
  input  logic               sync_clr,
  output logic               detect,
  output logic               irq,
  output logic               sym_first
);
  localparam int CNT_W = PKT_W + 3;

  logic [MAX_LEN-1:0] shreg, shnext;
  logic [LEN_W-1:0]   errs;
  logic [CNT_W-1:0]   left;
  logic               hit, phase, match;

  assign shnext = {shreg[MAX_LEN-2:0], bit_in};

  always_comb begin
    errs = '0;
    for (int i = 0; i < MAX_LEN; i++)
      if (LEN_W'(i) < cfg_len)
        errs = errs + LEN_W'(shnext[i] ^ cfg_word[i]);
  end

  assign match = bit_en && !hit && (errs <= LEN_W'(cfg_tol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      hit   <= 1'b0;
      phase <= 1'b0;
      left  <= '0;
    end else begin
      if (bit_en) begin
        shreg <= shnext;
        phase <= match ? 1'b0 : ~phase;
      end
      if (sync_clr) begin
        hit  <= 1'b0;
        left <= '0;
      end else if (match && cfg_mode != 2'b00) begin
        hit  <= !(cfg_mode == 2'b10 && cfg_pkt_bytes == '0);
        left <= {cfg_pkt_bytes, 3'b000};
      end else if (bit_en && hit && cfg_mode == 2'b10) begin
        left <= left - 1'b1;
        if (left == CNT_W'(1)) hit <= 1'b0;
      end
    end
  end

  assign detect    = hit && (cfg_mode == 2'b01 || cfg_mode == 2'b10);
  assign irq       = hit && (cfg_mode == 2'b11);
  assign sym_first = !four_level || !phase;
endmodule

// File: rtl/sync_detect_chk.sv
module sync_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic [1:0] cfg_mode,
  input logic       four_level,
  input logic       sync_clr,
  input logic       match,
  input logic       detect,
  input logic       irq,
  input logic       sym_first
);
  p_rise_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(detect) && $stable(cfg_mode)) |-> ($past(bit_en) && !$past(sync_clr)));

  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !sync_clr && cfg_mode == 2'b11) |=> (irq || cfg_mode != 2'b11));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_clr) |-> (!detect && !irq));

  p_align_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_en) && $past(match) && four_level) |-> sym_first);

  p_align_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_en) && !$past(match) && four_level && $past(four_level))
      |-> (sym_first != $past(sym_first)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bit_en) && !$past(sync_clr) && $stable(cfg_mode))
      |-> ($stable(detect) && $stable(irq)));
endmodule

bind sync_detect sync_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_mode(cfg_mode),
  .four_level(four_level), .sync_clr(sync_clr), .match(match),
  .detect(detect), .irq(irq), .sym_first(sym_first)
);

// File: tb/sync_detect_tb.sv
`timescale 1ns/1ps
module sync_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, bit_in = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic [23:0] cfg_word = '0;
  logic [4:0]  cfg_len = 5'd16;
  logic [1:0]  cfg_tol = 2'd0;
  logic [7:0]  cfg_pkt_bytes = '0;
  logic        four_level = 1'b0, sync_clr = 1'b0;
  logic        detect, irq, sym_first;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sync_detect u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .cfg_mode(cfg_mode), .cfg_word(cfg_word), .cfg_len(cfg_len),
    .cfg_tol(cfg_tol), .cfg_pkt_bytes(cfg_pkt_bytes),
    .four_level(four_level), .sync_clr(sync_clr),
    .detect(detect), .irq(irq), .sym_first(sym_first)
  );

  // {four_level, mode, tol, len, pkt_bytes, expect_match, word, sent}
  localparam logic [62:0] VEC [8] = '{
    {1'b1, 2'b01, 2'd0, 5'd16, 4'd0, 1'b1, 24'h00E5A3, 24'h00E5A3},
    {1'b0, 2'b01, 2'd0, 5'd16, 4'd0, 1'b0, 24'h00E5A3, 24'h00E5A2},
    {1'b0, 2'b01, 2'd2, 5'd24, 4'd0, 1'b1, 24'hE2F4C9, 24'hE2FCC8},
    {1'b0, 2'b01, 2'd2, 5'd24, 4'd0, 1'b0, 24'hE2F4C9, 24'hF2FCC8},
    {1'b1, 2'b10, 2'd1, 5'd16, 4'd2, 1'b1, 24'h00E5A3, 24'h00E5A3},
    {1'b0, 2'b11, 2'd0, 5'd8,  4'd0, 1'b1, 24'h0000E2, 24'h0000E2},
    {1'b1, 2'b00, 2'd0, 5'd16, 4'd0, 1'b1, 24'h00E5A3, 24'h00E5A3},
    {1'b0, 2'b10, 2'd0, 5'd12, 4'd0, 1'b1, 24'h000E3C, 24'h000E3C}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); sync_clr = 1'b1;
    @(negedge clk); sync_clr = 1'b0;
  endtask

  function automatic logic stream_bit(int k, int len, logic [23:0] sent);
    if (k < 16) return (k % 2 == 0);
    if (k < 16 + len) return sent[len - 1 - (k - 16)];
    return 1'b0;
  endfunction

  task automatic run_vec(input logic [62:0] e);
    int len, h, pkt;
    logic [1:0] mode;
    string tag;
    logic ed, ei;
    len = int'(e[57:53]); pkt = int'(e[52:49]); mode = e[61:60];
    four_level = e[62]; cfg_mode = mode; cfg_tol = e[59:58];
    cfg_len = e[57:53]; cfg_pkt_bytes = 8'(e[52:49]); cfg_word = e[47:24];
    pulse_clr();
    chk("R7", detect, 1'b0);
    chk("R7", irq, 1'b0);
    h = e[48] ? 16 + len - 1 : 1000;
    case (mode)
      2'b00: tag = "R3";
      2'b01: tag = (e[59:58] != 0) ? "R2" : "R4";
      2'b10: tag = "R5";
      default: tag = "R6";
    endcase
    if (!e[48]) tag = "R9";
    for (int k = 0; k < 64; k++) begin
      send_bit(stream_bit(k, len, e[23:0]));
      ed = (mode == 2'b01 && k >= h) ||
           (mode == 2'b10 && k >= h && k < h + 8 * pkt);
      ei = (mode == 2'b11 && k >= h);
      chk(tag, detect, ed);
      chk(tag, irq, ei);
      if (e[62] && k >= h) chk("R8", sym_first, ((k - h) % 2) == 0);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", detect, 1'b0);
    chk("R1", irq, 1'b0);
    chk("R1", sym_first, 1'b1);

    for (int v = 0; v < 8; v++) run_vec(VEC[v]);

    // Directed: latch mode hold, clear, binary alignment
    four_level = 1'b0; cfg_mode = 2'b01; cfg_tol = 2'd0;
    cfg_len = 5'd16; cfg_word = 24'h00E5A3;
    pulse_clr();
    for (int k = 0; k < 32; k++) send_bit(stream_bit(k, 16, 24'h00E5A3));
    chk("R4", detect, 1'b1);
    repeat (6) @(negedge clk);
    chk("R10", detect, 1'b1);
    chk("R10", irq, 1'b0);
    send_bit(1'b0);
    chk("R4", detect, 1'b1);
    chk("R8", sym_first, 1'b1);
    send_bit(1'b1);
    chk("R8", sym_first, 1'b1);
    pulse_clr();
    chk("R7", detect, 1'b0);

    // Directed: interrupt stays through idle clocks, then clears
    cfg_mode = 2'b11; cfg_len = 5'd8; cfg_word = 24'h0000E2;
    pulse_clr();
    for (int k = 0; k < 24; k++) send_bit(stream_bit(k, 8, 24'h0000E2));
    chk("R6", irq, 1'b1);
    chk("R6", detect, 1'b0);
    repeat (5) @(negedge clk);
    chk("R10", irq, 1'b1);
    pulse_clr();
    chk("R7", irq, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule